// File: doc/BRIEF.md
# Early-Prompt-Late Replica Code Generator

This block produces three time-shifted copies of a spreading code for one tracking channel of a spread-spectrum receiver. A 32-bit phase accumulator, stepped every system clock by a frequency word from the tracking loop, emits a one-cycle tick each time it wraps. Ticks arrive at twice the chip rate. A toggle flag passes every second tick on as a chip step, which advances a 10-stage LFSR standing in for the real code table.

The LFSR's output bit is the early replica. A two-stage delay line, shifted on every double-rate tick, turns it into prompt (half a chip later) and late (one chip after early). The processor can load the accumulator phase, the LFSR state and the toggle flag in one cycle, to set the starting alignment during search or reacquisition. An epoch pulse marks each return of the code to its all-ones start state. Frequency words of a quarter of the accumulator range or more are clamped, so that the system clock always runs at least four times faster than the tick rate.

Top module: `epl_code_gen`

## Requirements
- R1: While `rst_ni` is low, the accumulator, tick and toggle flag are zero, the LFSR holds all ones and the delay line holds zeros. So `early_o`=1 and `prompt_o`, `late_o`, `half_tick_o`, `chip_stb_o` and `epoch_o` are all 0.
- R2: Each clock, the accumulator adds the effective frequency word modulo 2^32. `half_tick_o` is high for exactly the cycle after an addition that carried out of bit 31. A new word takes effect at the next edge.
- R3: A frequency word of 2^30 or more is treated as 2^30-1. Two `half_tick_o` pulses are therefore never less than 4 cycles apart unless a preset intervenes.
- R4: `chip_stb_o` is high only in a `half_tick_o` cycle, and only when the toggle flag is 1. Each tick inverts the flag, so chip steps fall on every second tick.
- R5: On each chip step, the LFSR state s[9:0] becomes {s[8:0], s[9]^s[2]} (taps 10 and 3). `early_o` is s[9] and does not change in any other cycle except a preset.
- R6: On each `half_tick_o` cycle, prompt takes the current early value and late takes the current prompt value, so late trails early by one chip. Neither changes on other cycles.
- R7: `preset_i` loads `preset_phase_i` into the accumulator, `preset_state_i` into the LFSR and `preset_flag_i` into the toggle flag, and clears the pending tick and epoch. It overrides stepping, but it does not stop a shift of the delay line that falls in the same cycle.
- R8: `epoch_o` is high for one cycle after a chip step that leaves the LFSR at all ones (never after a preset), so it recurs every 1023 chip steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (NCO reference) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| freq_word_i | input | 32 | Frequency word added to the accumulator each cycle |
| preset_i | input | 1 | Load phase, code state and toggle flag |
| preset_phase_i | input | 32 | Accumulator value loaded on preset |
| preset_state_i | input | 10 | LFSR state loaded on preset |
| preset_flag_i | input | 1 | Toggle flag loaded on preset (1: next tick steps the code) |
| half_tick_o | output | 1 | Pulse at twice the chip rate |
| chip_stb_o | output | 1 | Pulse when the code advances one chip |
| early_o | output | 1 | Early replica |
| prompt_o | output | 1 | Prompt replica, half a chip behind early |
| late_o | output | 1 | Late replica, one chip behind early |
| epoch_o | output | 1 | Code epoch pulse |

## Verification
The hardest case to reach is a preset that lands in the same cycle as a pending tick, or just before a wrap. Here a load must win over a chip step while the delay line still shifts. The bench forces it by loading accumulator phases a few words below the wrap point, with the toggle flag set, and by firing many presets at random moments under random frequency words. Reaching the epoch takes over two thousand ticks, so the bench also runs at the clamped maximum rate long enough to see two epochs and count the chips between them.

// File: rtl/epl_pkg.sv
package epl_pkg;
  localparam int unsigned ACC_W_DEF  = 32;
  localparam int unsigned CODE_W_DEF = 10;

  typedef struct packed {
    logic early;
    logic prompt;
    logic late;
  } replica_t;
endpackage

// File: rtl/epl_nco.sv
module epl_nco #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq_word_i,
  input  logic             load_i,
  input  logic [ACC_W-1:0] load_phase_i,
  output logic             tick_o
);
  // words >= quarter range are clamped: keeps ref clock >= 4x tick rate
  localparam logic [ACC_W-1:0] FW_MAX = {2'b00, {(ACC_W-2){1'b1}}};

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] fw_eff;
  logic [ACC_W:0]   sum;
  logic             tick_q;

  always_comb begin
    fw_eff = (freq_word_i > FW_MAX) ? FW_MAX : freq_word_i;
    sum    = {1'b0, acc_q} + {1'b0, fw_eff};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (load_i) begin
      acc_q  <= load_phase_i;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/epl_chip_div.sv
module epl_chip_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  logic load_flag_i,
  output logic step_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (load_i)  flag_q <= load_flag_i;
    else if (tick_i)  flag_q <= ~flag_q;
  end

  assign step_o = tick_i & flag_q;
endmodule

// File: rtl/epl_lfsr.sv
module epl_lfsr #(
  parameter int unsigned W     = 10,
  parameter int unsigned TAP_B = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_state_i,
  output logic         chip_o,
  output logic         epoch_o
);
  localparam logic [W-1:0] INIT = {W{1'b1}};

  logic [W-1:0] state_q;
  logic [W-1:0] nxt;
  logic         epoch_q;

  assign nxt = {state_q[W-2:0], state_q[W-1] ^ state_q[TAP_B-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= INIT;
      epoch_q <= 1'b0;
    end else if (load_i) begin
      state_q <= load_state_i;
      epoch_q <= 1'b0;
    end else begin
      if (step_i) state_q <= nxt;
      epoch_q <= step_i && (nxt == INIT);
    end
  end

  assign chip_o  = state_q[W-1];
  assign epoch_o = epoch_q;
endmodule

// File: rtl/epl_delay_line.sv
module epl_delay_line #(
  parameter int unsigned DEPTH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           din_i,
  output logic [DEPTH:1] taps_o
);
  logic [DEPTH:0] chain;

  assign chain[0] = din_i;

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      chain[i] <= 1'b0;
      else if (shift_i) chain[i] <= chain[i-1];
    end
  end

  assign taps_o = chain[DEPTH:1];
endmodule

// File: rtl/epl_code_gen.sv
module epl_code_gen
  import epl_pkg::*;
#(
  parameter int unsigned ACC_W  = ACC_W_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned TAP_B  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  freq_word_i,
  input  logic              preset_i,
  input  logic [ACC_W-1:0]  preset_phase_i,
  input  logic [CODE_W-1:0] preset_state_i,
  input  logic              preset_flag_i,
  output logic              half_tick_o,
  output logic              chip_stb_o,
  output logic              early_o,
  output logic              prompt_o,
  output logic              late_o,
  output logic              epoch_o
);
  localparam int unsigned DLY = 2;

  logic           tick;
  logic           step;
  logic           code_bit;
  logic [DLY:1]   taps;
  replica_t       rep;

  epl_nco #(.ACC_W(ACC_W)) u_nco (
    .clk_i, .rst_ni,
    .freq_word_i,
    .load_i       (preset_i),
    .load_phase_i (preset_phase_i),
    .tick_o       (tick)
  );

  epl_chip_div u_div (
    .clk_i, .rst_ni,
    .tick_i      (tick),
    .load_i      (preset_i),
    .load_flag_i (preset_flag_i),
    .step_o      (step)
  );

  epl_lfsr #(.W(CODE_W), .TAP_B(TAP_B)) u_lfsr (
    .clk_i, .rst_ni,
    .step_i       (step),
    .load_i       (preset_i),
    .load_state_i (preset_state_i),
    .chip_o       (code_bit),
    .epoch_o      (epoch_o)
  );

  // shifts on every tick, preset or not
  epl_delay_line #(.DEPTH(DLY)) u_dly (
    .clk_i, .rst_ni,
    .shift_i (tick),
    .din_i   (code_bit),
    .taps_o  (taps)
  );

  assign rep = '{early: code_bit, prompt: taps[1], late: taps[2]};

  assign half_tick_o = tick;
  assign chip_stb_o  = step;
  assign early_o     = rep.early;
  assign prompt_o    = rep.prompt;
  assign late_o      = rep.late;
endmodule

// File: rtl/epl_code_gen_chk.sv
module epl_code_gen_chk #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned CODE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ACC_W-1:0]  freq_word_i,
  input logic              preset_i,
  input logic [ACC_W-1:0]  preset_phase_i,
  input logic [CODE_W-1:0] preset_state_i,
  input logic              preset_flag_i,
  input logic              half_tick_o,
  input logic              chip_stb_o,
  input logic              early_o,
  input logic              prompt_o,
  input logic              late_o,
  input logic              epoch_o
);
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_tick_o && !$past(preset_i) && !$past(preset_i, 2) && !$past(preset_i, 3))
    |-> (!$past(half_tick_o) && !$past(half_tick_o, 2) && !$past(half_tick_o, 3)));

  a_r4_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_stb_o |-> half_tick_o);

  a_r5_early_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chip_stb_o && !preset_i) |=> $stable(early_o));

  a_r6_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick_o |=> (prompt_o == $past(early_o)) && (late_o == $past(prompt_o)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_tick_o |=> $stable(prompt_o) && $stable(late_o));

  a_r7_preset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> !half_tick_o && !chip_stb_o && !epoch_o);

  a_r8_epoch_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_o |-> ($past(chip_stb_o) && early_o));
endmodule

bind epl_code_gen epl_code_gen_chk #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/epl_code_gen_bench.sv
module epl_code_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fw = '0;
  logic        pre = 1'b0;
  logic [31:0] pre_phase = '0;
  logic [9:0]  pre_state = '0;
  logic        pre_flag = 1'b0;
  logic        half_tick, chip_stb, early, prompt, late, epoch;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  epl_code_gen u_epl_code_gen (
    .clk_i(clk), .rst_ni(rst_n), .freq_word_i(fw),
    .preset_i(pre), .preset_phase_i(pre_phase), .preset_state_i(pre_state),
    .preset_flag_i(pre_flag),
    .half_tick_o(half_tick), .chip_stb_o(chip_stb), .early_o(early),
    .prompt_o(prompt), .late_o(late), .epoch_o(epoch)
  );

  // behavioural reference
  longint unsigned m_acc;
  bit m_tick, m_tog, m_epoch;
  int m_code;
  bit m_dly[$];

  function automatic bit m_early();
    return bit'((m_code >> 9) & 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_tick = 0; m_tog = 0; m_epoch = 0; m_code = 1023;
      m_dly = '{0, 0};
    end else begin
      longint unsigned w, s;
      bit e_old, step;
      int nc;
      e_old = m_early();
      step  = m_tick && m_tog;
      if (m_tick) begin
        m_dly.push_front(e_old);
        void'(m_dly.pop_back());
      end
      if (pre) begin
        m_acc = pre_phase; m_tick = 0; m_tog = pre_flag;
        m_code = int'(pre_state); m_epoch = 0;
      end else begin
        w = (fw >= 32'h4000_0000) ? 64'h3FFF_FFFF : 64'(fw);
        s = m_acc + w;
        m_acc = s & 64'hFFFF_FFFF;
        if (m_tick) m_tog = !m_tog;
        m_epoch = 0;
        if (step) begin
          nc = ((m_code << 1) & 1023) | (((m_code >> 9) ^ (m_code >> 2)) & 1);
          m_code = nc;
          m_epoch = (nc == 1023);
        end
        m_tick = bit'(s >> 32);
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison and spec-level counters
  int gap = 100, pre_age = 100, chips = 0, epochs = 0, last_period = 0, period_ok = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 half_tick", half_tick, m_tick);
      chk("R4 chip_stb", chip_stb, m_tick && m_tog);
      chk("R5 early", early, m_early());
      chk("R6 prompt", prompt, m_dly[0]);
      chk("R6 late", late, m_dly[1]);
      chk("R8 epoch", epoch, m_epoch);
      gap++;
      if (half_tick) begin
        if (pre_age > 3) chk("R3 tick spacing >=4", gap >= 4, 1'b1);
        gap = 0;
      end
      if (chip_stb) chips++;
      if (epoch) begin
        epochs++;
        if (epochs >= 2) begin last_period = chips; period_ok++; end
        chips = 0;
      end
      pre_age = pre ? 0 : pre_age + 1;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 early", early, 1'b1);
    chk("R1 prompt", prompt, 1'b0);
    chk("R1 late", late, 1'b0);
    chk("R1 half_tick", half_tick, 1'b0);
    chk("R1 chip_stb", chip_stb, 1'b0);
    chk("R1 epoch", epoch, 1'b0);
    rst_n = 1'b1;

    // R2/R4/R5/R6 nominal rate: tick every 8 cycles
    fw = 32'h2000_0000;
    cyc(400);
    fw = 32'h1234_5678;
    cyc(400);

    // R3 clamped word, long run for R8 epoch period
    fw = 32'hFFFF_FFFF;
    chips = 0; epochs = 0;
    cyc(17500);
    chk("R8 two epochs seen", epochs >= 2, 1'b1);
    chk("R8 period 1023", last_period == 1023, 1'b1);

    // R7 preset just below the wrap, flag set
    fw = 32'h0000_0200;
    pre = 1; pre_phase = 32'hFFFF_FF00; pre_state = 10'h155; pre_flag = 1;
    cyc(1);
    pre = 0;
    chk("R7 early after preset", early, 1'b0);
    chk("R7 no tick after preset", half_tick, 1'b0);
    cyc(1);
    chk("R7 tick after wrap", half_tick, 1'b1);
    chk("R7 step with flag", chip_stb, 1'b1);
    cyc(1);
    chk("R7 code advanced", early, 1'b1);

    // R8 preset to all ones gives no epoch
    pre = 1; pre_state = 10'h3FF; pre_phase = 32'h0; pre_flag = 0;
    cyc(1);
    pre = 0;
    chk("R8 no epoch on preset", epoch, 1'b0);
    cyc(50);

    // R7 random presets under random words
    for (int i = 0; i < 60; i++) begin
      fw = $urandom;
      if (i % 3 == 0) fw = fw >> 2;
      cyc(int'($urandom_range(1, 40)));
      pre = 1;
      pre_phase = 32'hFFFF_FFFF - ($urandom & 32'h3FFF_FFFF);
      pre_state = 10'($urandom);
      pre_flag  = 1'($urandom);
      cyc(int'($urandom_range(1, 2)));
      pre = 0;
    end
    cyc(200);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule